// File: doc/BRIEF.md
# Floating-Point Compare and Condition-Code Unit

This block compares two floating-point operands and records the outcome as a condition-code bit in a 32-bit control/status register. The operands can be single precision (low 32 bits of each operand bus), double precision (the full 64 bits) or paired single, where each 64-bit operand carries two independent 32-bit values that are compared lane by lane. Each operation selects an ordered predicate (equal, less-than, less-or-equal), says whether an unordered comparison counts as true or false, and can ask for an invalid-operation report when a quiet NaN appears.

An operation is presented with `valid_i` high for one cycle and takes effect in the status register at the next rising clock edge. Every operation first wipes the cause field of the register. Either the result goes into the chosen condition-code bit, or, in the signalling variant with a quiet-NaN operand, the invalid cause bit and the sticky invalid flag are set and the condition code is left as it was. The only other output is `invalid_o`, the invalid cause bit of the most recent operation.

Top module: `fpcmp_unit`

## Requirements
- R1: A synchronous active-high reset clears the whole status register to zero, and `invalid_o` reads 0 after it.
- R2: In a cycle where `valid_i` is low, the status register keeps its value, whatever the other inputs carry.
- R3: Each operation clears status bits 17 to 12 (the cause field) before its own updates. Bits 31 to 18 and 11 to 0 keep their value unless the operation writes them.
- R4: `fmt_i` selects the format: 0 single (operands in `fs_i[31:0]`/`ft_i[31:0]`, upper halves ignored), 1 double (full 64 bits), 2 paired single, 3 behaves as single. A value is a NaN when its exponent field is all ones and its fraction is non-zero. It is a quiet NaN when, in addition, the fraction MSB (bit 22 single, bit 51 double) is 1. Both tests use the width of the selected format.
- R5: When `sig_qnan_i` is 1 and either operand of a lane is a quiet NaN, that lane sets status bit 16 (invalid cause) and bit 6 (invalid flag) and leaves its condition-code bit unchanged. A signalling NaN never raises the invalid indication.
- R6: When a lane is not aborted and either operand is any NaN, the condition result equals `unord_true_i`.
- R7: With no NaN operand, the result is the ordered predicate chosen by `pred_i`: 0 equal, 1 less-than (fs < ft), 2 less-or-equal, 3 always false. +0 and -0 compare equal, infinities order as the extreme values, and subnormals order by value.
- R8: Condition-code index 0 writes status bit 23. Index k in 1..7 writes bit 24+k. No other bits outside 16 and 6 are ever set.
- R9: In paired-single mode the lower 32-bit lanes are compared and written at index `cc_idx_i`, and the upper lanes at index `cc_idx_i`+1 modulo 8. Each lane has its own abort, unordered handling and write.
- R10: The invalid flag (bit 6) stays set through later operations until reset. `invalid_o` equals status bit 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe, one cycle per compare |
| fmt_i | input | 2 | Operand format: 0 single, 1 double, 2 paired single |
| pred_i | input | 2 | Ordered predicate: 0 equal, 1 less, 2 less-or-equal, 3 false |
| unord_true_i | input | 1 | Result value used when an operand is NaN |
| sig_qnan_i | input | 1 | Treat a quiet NaN operand as an invalid operation |
| cc_idx_i | input | 3 | Condition-code index to write |
| fs_i | input | 64 | First operand |
| ft_i | input | 64 | Second operand |
| csr_o | output | 32 | Status/control register |
| invalid_o | output | 1 | Invalid-operation cause of the last operation |

## Verification
Every format is swept over all ordered pairs of a value set that holds signed zeros, ones, twos, infinities, subnormals, the largest finite value, a quiet NaN and a signalling NaN. Each pair is tried with every predicate, both unordered flags and both settings of the quiet-NaN signal flag. The zero and subnormal pairs separate a magnitude compare from a true signed compare. The NaN pairs separate the unordered path from the abort path, and the quiet-versus-signalling pairs show whether the NaN test uses the right bit. Single mode carries a quiet NaN in the ignored upper halves, which exposes a width mix-up. Paired runs give the two lanes different values, so a crossed lane or a wrong index shows up. Idle cycles with busy inputs and a reset after set flags cover holding and clearing.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    localparam int CSR_W      = 32;
    localparam int CC_IDX_W   = 3;
    localparam int OPND_W     = 64;
    localparam int SP_EXP_W   = 8;
    localparam int SP_MAN_W   = 23;
    localparam int SP_W       = 1 + SP_EXP_W + SP_MAN_W;
    localparam int DP_EXP_W   = 11;
    localparam int DP_MAN_W   = 52;
    localparam int PAIR_LANES = OPND_W / SP_W;

    localparam int CAUSE_LO      = 12;
    localparam int CAUSE_HI      = 17;
    localparam int INV_CAUSE_BIT = 16;
    localparam int INV_FLAG_BIT  = 6;
    localparam int CC0_BIT       = 23;
    localparam int CCN_BASE      = 24;

    localparam logic [CSR_W-1:0] CAUSE_MASK =
        ((CSR_W'(1) << (CAUSE_HI + 1)) - 1) & ~((CSR_W'(1) << CAUSE_LO) - 1);

    typedef enum logic [1:0] {
        FMT_SGL  = 2'd0,
        FMT_DBL  = 2'd1,
        FMT_PAIR = 2'd2,
        FMT_RSV  = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        PR_EQ   = 2'd0,
        PR_LT   = 2'd1,
        PR_LE   = 2'd2,
        PR_NONE = 2'd3
    } pred_e;

    typedef struct packed {
        logic abort;
        logic cond;
    } lane_res_t;

    function automatic logic [4:0] cc_bit_pos(input logic [CC_IDX_W-1:0] idx);
        if (idx == '0) begin
            return 5'(CC0_BIT);
        end
        return 5'(CCN_BASE) + 5'(idx);
    endfunction

    function automatic logic [CSR_W-1:0] apply_lane(input logic [CSR_W-1:0] c,
                                                    input lane_res_t r,
                                                    input logic [CC_IDX_W-1:0] idx);
        logic [CSR_W-1:0] n;
        n = c;
        if (r.abort) begin
            n[INV_CAUSE_BIT] = 1'b1;
            n[INV_FLAG_BIT]  = 1'b1;
        end else begin
            n[cc_bit_pos(idx)] = r.cond;
        end
        return n;
    endfunction

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
)
(
    input  logic [EXP_W+MAN_W:0] x_i,
    output logic                 is_nan_o,
    output logic                 is_qnan_o,
    output logic                 is_zero_o
);
    localparam int W = 1 + EXP_W + MAN_W;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             exp_max;

    assign exp_f   = x_i[W-2 -: EXP_W];
    assign man_f   = x_i[MAN_W-1:0];
    assign exp_max = &exp_f;

    assign is_nan_o  = exp_max && (man_f != '0);
    assign is_qnan_o = exp_max && man_f[MAN_W-1];
    assign is_zero_o = (x_i[W-2:0] == '0);
endmodule

// File: rtl/fpcmp_lane.sv
module fpcmp_lane
    import fpcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
)
(
    input  logic [EXP_W+MAN_W:0] a_i,
    input  logic [EXP_W+MAN_W:0] b_i,
    input  pred_e                pred_i,
    input  logic                 unord_true_i,
    input  logic                 sig_qnan_i,
    output lane_res_t            res_o
);
    localparam int W = 1 + EXP_W + MAN_W;

    logic a_nan, a_qnan, a_zero;
    logic b_nan, b_qnan, b_zero;

    fpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_a (
        .x_i(a_i), .is_nan_o(a_nan), .is_qnan_o(a_qnan), .is_zero_o(a_zero)
    );
    fpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_b (
        .x_i(b_i), .is_nan_o(b_nan), .is_qnan_o(b_qnan), .is_zero_o(b_zero)
    );

    logic         sgn_a, sgn_b;
    logic [W-2:0] mag_a, mag_b;
    logic         ord_eq, ord_lt, ord_res;

    assign sgn_a = a_i[W-1];
    assign sgn_b = b_i[W-1];
    assign mag_a = a_i[W-2:0];
    assign mag_b = b_i[W-2:0];

    always_comb begin
        ord_eq = (a_zero && b_zero) || (a_i == b_i);
        if (a_zero && b_zero) begin
            ord_lt = 1'b0;
        end else begin
            case ({sgn_a, sgn_b})
                2'b10:   ord_lt = 1'b1;
                2'b01:   ord_lt = 1'b0;
                2'b00:   ord_lt = (mag_a < mag_b);
                default: ord_lt = (mag_a > mag_b);
            endcase
        end
        case (pred_i)
            PR_EQ:   ord_res = ord_eq;
            PR_LT:   ord_res = ord_lt;
            PR_LE:   ord_res = ord_lt || ord_eq;
            default: ord_res = 1'b0;
        endcase
    end

    always_comb begin
        res_o.abort = sig_qnan_i && (a_qnan || b_qnan);
        res_o.cond  = (a_nan || b_nan) ? unord_true_i : ord_res;
    end
endmodule

// File: rtl/fpcmp_csr_next.sv
module fpcmp_csr_next
    import fpcmp_pkg::*;
(
    input  logic [CSR_W-1:0]    csr_i,
    input  fmt_e                fmt_i,
    input  logic [CC_IDX_W-1:0] idx_i,
    input  lane_res_t           lo_i,
    input  lane_res_t           hi_i,
    input  lane_res_t           dbl_i,
    output logic [CSR_W-1:0]    csr_o
);
    logic [CC_IDX_W-1:0] idx_hi;
    logic [CSR_W-1:0]    base;

    assign idx_hi = idx_i + CC_IDX_W'(1);
    assign base   = csr_i & ~CAUSE_MASK;

    always_comb begin
        case (fmt_i)
            FMT_DBL:  csr_o = apply_lane(base, dbl_i, idx_i);
            FMT_PAIR: csr_o = apply_lane(apply_lane(base, lo_i, idx_i), hi_i, idx_hi);
            default:  csr_o = apply_lane(base, lo_i, idx_i);
        endcase
    end
endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
    import fpcmp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                valid_i,
    input  logic [1:0]          fmt_i,
    input  logic [1:0]          pred_i,
    input  logic                unord_true_i,
    input  logic                sig_qnan_i,
    input  logic [CC_IDX_W-1:0] cc_idx_i,
    input  logic [OPND_W-1:0]   fs_i,
    input  logic [OPND_W-1:0]   ft_i,
    output logic [CSR_W-1:0]    csr_o,
    output logic                invalid_o
);
    fmt_e  fmt;
    pred_e pred;

    assign fmt  = fmt_e'(fmt_i);
    assign pred = pred_e'(pred_i);

    lane_res_t sp_res [PAIR_LANES];
    lane_res_t dp_res;

    for (genvar g = 0; g < PAIR_LANES; g++) begin : g_sp
        fpcmp_lane #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W)) u_lane (
            .a_i          (fs_i[SP_W*g +: SP_W]),
            .b_i          (ft_i[SP_W*g +: SP_W]),
            .pred_i       (pred),
            .unord_true_i (unord_true_i),
            .sig_qnan_i   (sig_qnan_i),
            .res_o        (sp_res[g])
        );
    end

    fpcmp_lane #(.EXP_W(DP_EXP_W), .MAN_W(DP_MAN_W)) u_dp_lane (
        .a_i          (fs_i),
        .b_i          (ft_i),
        .pred_i       (pred),
        .unord_true_i (unord_true_i),
        .sig_qnan_i   (sig_qnan_i),
        .res_o        (dp_res)
    );

    logic [CSR_W-1:0] csr_q, csr_d;

    fpcmp_csr_next u_next (
        .csr_i (csr_q),
        .fmt_i (fmt),
        .idx_i (cc_idx_i),
        .lo_i  (sp_res[0]),
        .hi_i  (sp_res[PAIR_LANES-1]),
        .dbl_i (dp_res),
        .csr_o (csr_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            csr_q <= '0;
        end else if (valid_i) begin
            csr_q <= csr_d;
        end
    end

    assign csr_o     = csr_q;
    assign invalid_o = csr_q[INV_CAUSE_BIT];
endmodule

// File: rtl/fpcmp_checker.sv
module fpcmp_checker (
    input logic        clk,
    input logic        rst,
    input logic        valid_i,
    input logic        sig_qnan_i,
    input logic [31:0] csr_o,
    input logic        invalid_o
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (csr_o == 32'h0)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(csr_o)); // R2

    AST_CAUSE_ONLY_INV: assert property (@(posedge clk) disable iff (rst)
        (csr_o[17] == 1'b0) && (csr_o[15:12] == 4'h0)); // R3

    AST_NO_STRAY_BITS: assert property (@(posedge clk) disable iff (rst)
        (csr_o[22:18] == 5'h0) && (csr_o[11:7] == 5'h0) && (csr_o[5:0] == 6'h0)); // R8

    AST_NO_INVALID_UNSIGNALLED: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !sig_qnan_i) |=> !invalid_o); // R5

    AST_CAUSE_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
        invalid_o |-> csr_o[6]); // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        csr_o[6] |=> csr_o[6]); // R10
endmodule

bind fpcmp_unit fpcmp_checker u_fpcmp_checker (
    .clk        (clk),
    .rst        (rst),
    .valid_i    (valid_i),
    .sig_qnan_i (sig_qnan_i),
    .csr_o      (csr_o),
    .invalid_o  (invalid_o)
);

// File: tb/tb_fpcmp_unit.sv
`timescale 1ns/1ps
module tb_fpcmp_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [1:0]  fmt_i = 2'd0;
    logic [1:0]  pred_i = 2'd0;
    logic        unord_true_i = 1'b0;
    logic        sig_qnan_i = 1'b0;
    logic [2:0]  cc_idx_i = 3'd0;
    logic [63:0] fs_i = '0;
    logic [63:0] ft_i = '0;
    logic [31:0] csr_o;
    logic        invalid_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] exp_csr = '0;

    always #4 clk = ~clk;

    fpcmp_unit dut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .fmt_i(fmt_i), .pred_i(pred_i),
        .unord_true_i(unord_true_i), .sig_qnan_i(sig_qnan_i), .cc_idx_i(cc_idx_i),
        .fs_i(fs_i), .ft_i(ft_i), .csr_o(csr_o), .invalid_o(invalid_o)
    );

    logic [31:0] spv [13] = '{32'h00000000, 32'h80000000, 32'h3f800000, 32'hbf800000,
                              32'h40000000, 32'hc0000000, 32'h7f800000, 32'hff800000,
                              32'h7fc00000, 32'h7f800001, 32'h00000001, 32'h807fffff,
                              32'h7f7fffff};
    logic [63:0] dpv [12] = '{64'h0, 64'h8000000000000000, 64'h3ff0000000000000,
                              64'hbff0000000000000, 64'h4000000000000000, 64'hc000000000000000,
                              64'h7ff0000000000000, 64'hfff0000000000000, 64'h7ff8000000000000,
                              64'h7ff0000000000001, 64'h0000000000000001, 64'h7fefffffffffffff};

    function automatic bit nan32(logic [31:0] x);  return (x[30:23] == 8'hff) && (x[22:0] != 0); endfunction
    function automatic bit qnan32(logic [31:0] x); return (x[30:23] == 8'hff) && x[22]; endfunction
    function automatic bit nan64(logic [63:0] x);  return (x[62:52] == 11'h7ff) && (x[51:0] != 0); endfunction
    function automatic bit qnan64(logic [63:0] x); return (x[62:52] == 11'h7ff) && x[51]; endfunction

    function automatic real sp_real(logic [31:0] x);
        real m;
        int  e;
        e = int'(x[30:23]);
        if (e == 255)    m = 1.0e300;
        else if (e == 0) m = real'(x[22:0]) * (2.0 ** (-149));
        else             m = real'(int'(x[22:0]) + 8388608) * (2.0 ** (e - 150));
        return x[31] ? -m : m;
    endfunction

    // Model of one lane per R5, R6, R7, R8
    task automatic model_lane(input bit na, input bit nb, input bit qa, input bit qb,
                              input real ra, input real rb, input logic [1:0] pr,
                              input bit ut, input bit sq, input logic [2:0] idx);
        bit c;
        int pos;
        if (sq && (qa || qb)) begin
            exp_csr[16] = 1'b1;
            exp_csr[6]  = 1'b1;
        end else begin
            if (na || nb) c = ut;
            else case (pr)
                2'd0: c = (ra == rb);
                2'd1: c = (ra < rb);
                2'd2: c = (ra <= rb);
                default: c = 1'b0;
            endcase
            pos = (idx == 0) ? 23 : 24 + int'(idx);
            exp_csr[pos] = c;
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_op(input string tag, input logic [1:0] f, input logic [1:0] pr,
                         input bit ut, input bit sq, input logic [2:0] idx,
                         input logic [63:0] a, input logic [63:0] b);
        valid_i = 1'b1; fmt_i = f; pred_i = pr; unord_true_i = ut;
        sig_qnan_i = sq; cc_idx_i = idx; fs_i = a; ft_i = b;
        exp_csr[17:12] = 6'h0; // R3
        if (f == 2'd1) begin
            model_lane(nan64(a), nan64(b), qnan64(a), qnan64(b),
                       $bitstoreal(a), $bitstoreal(b), pr, ut, sq, idx);
        end else begin
            model_lane(nan32(a[31:0]), nan32(b[31:0]), qnan32(a[31:0]), qnan32(b[31:0]),
                       sp_real(a[31:0]), sp_real(b[31:0]), pr, ut, sq, idx);
            if (f == 2'd2) begin // R9
                model_lane(nan32(a[63:32]), nan32(b[63:32]), qnan32(a[63:32]), qnan32(b[63:32]),
                           sp_real(a[63:32]), sp_real(b[63:32]), pr, ut, sq, idx + 3'd1);
            end
        end
        @(negedge clk);
        valid_i = 1'b0;
        chk(tag, csr_o, exp_csr);
        chk({tag, " R10 invalid_o"}, {31'h0, invalid_o}, {31'h0, exp_csr[16]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset state", csr_o, 32'h0);
        chk("R1 reset invalid_o", {31'h0, invalid_o}, 32'h0);
        rst = 1'b0;

        // Single format, upper halves hold a quiet NaN that must be ignored (R4)
        for (int i = 0; i < 13; i++)
            for (int j = 0; j < 13; j++)
                for (int k = 0; k < 16; k++)
                    do_op("R4 R6 R7 R8 single", (k[3] && i[0]) ? 2'd3 : 2'd0, k[1:0], k[2], k[3],
                          3'((i + j + k) % 8), {32'h7fc00000, spv[i]}, {32'h7fc00000, spv[j]});

        // Double format (R4, R5, R6, R7)
        for (int i = 0; i < 12; i++)
            for (int j = 0; j < 12; j++)
                for (int k = 0; k < 16; k++)
                    do_op("R4 R5 R6 R7 double", 2'd1, k[1:0], k[2], k[3],
                          3'((i * 3 + j + k) % 8), dpv[i], dpv[j]);

        // Paired single, lanes carry different values (R9)
        for (int i = 0; i < 13; i++)
            for (int j = 0; j < 13; j++)
                for (int k = 0; k < 16; k++)
                    do_op("R9 R3 R5 paired", 2'd2, k[1:0], k[2], k[3], 3'((i + 2 * j + k) % 8),
                          {spv[(i + 3) % 13], spv[i]}, {spv[(j + 5) % 13], spv[j]});

        // Idle cycles with busy inputs: no change (R2)
        for (int n = 0; n < 8; n++) begin
            valid_i = 1'b0; fmt_i = 2'(n); pred_i = 2'(n + 1); sig_qnan_i = 1'b1;
            unord_true_i = n[0]; cc_idx_i = 3'(n);
            fs_i = {spv[8], spv[8]}; ft_i = {spv[n], spv[n]};
            @(negedge clk);
            chk("R2 idle hold", csr_o, exp_csr);
        end

        // Sticky flag and cause clear (R10, R3)
        do_op("R5 abort", 2'd0, 2'd0, 1'b1, 1'b1, 3'd2, {32'h0, spv[8]}, 64'h0);
        do_op("R3 R10 clean op", 2'd0, 2'd0, 1'b1, 1'b0, 3'd2, 64'h0, 64'h0);
        chk("R10 flag kept", {31'h0, csr_o[6]}, 32'h1);
        chk("R3 cause cleared", {31'h0, csr_o[16]}, 32'h0);

        // Reset clears everything again (R1)
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_csr = '0;
        chk("R1 reset after use", csr_o, 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule